// File: doc/BRIEF.md
# Crypto Engine Command Queue Decoder

This block sits between a host and a crypto datapath. The host pushes 32-bit command words through a one-word-per-cycle write port into a short inbound queue. A sequencer takes words from the head of the queue and decodes the 6-bit operation code in bits [31:26]. It then drives one of five actions: program a DMA address, start the block engine for a given number of 16-byte blocks, signal DMA completion, launch a memory move between external memory and internal RAM, or copy a 64-byte key table (16 words) from internal RAM into a chosen key slot.

The crypto core, the DMA masters and the memories are outside the block. The block reaches them through simple pulse and done handshakes. The host polls three status bits: engine busy, queue empty and DMA busy. It waits while the engine is busy and the queue still holds words. Three sticky flags cover a bad command, a write to a full queue and a completed operation. The completion flag drives a level-high interrupt, and each sticky flag is cleared by writing 1 to its bit.

The sequencer has six named states:
- IDLE: takes the head word and dispatches it.
- DADDR: waits for the address word of a DMA setup.
- MADDR: waits for the address word of a memory move.
- MDMA: waits for the memory move to finish.
- CRYPT: waits for the block engine to finish.
- TBL: steps through the key-table words.

The transitions are:
- IDLE goes to DADDR on a DMA setup.
- IDLE goes to MADDR on a memory move.
- IDLE goes to CRYPT on a block start.
- IDLE goes to TBL on a well-formed table load.
- IDLE stays in IDLE on a DMA complete or on a dropped command.
- DADDR returns to IDLE once its address word arrives.
- MADDR goes to MDMA once its address word arrives.
- MDMA returns to IDLE on `mdma_done`.
- CRYPT returns to IDLE on `eng_done`.
- TBL returns to IDLE after the last word.

Top module: `crypto_cmdq`

## Requirements
- R1: After reset the queue reports empty, the engine and DMA busy bits are low, all sticky flags are low and `irq` is low.
- R2: The queue holds QDEPTH (default 5) words, and `stat_q_empty` is low while any word is waiting.
- R3: A write while the queue is full is discarded and is never executed. It sets `stat_ovf`, which writing 1 to clear bit 1 resets.
- R4: Opcode 0x10 (DMA setup) consumes the next queue word and emits exactly one `dset_valid` pulse, with that word on `dset_addr`.
- R5: Opcode 0x0E (block start) emits one `eng_start` pulse with `eng_blocks` equal to bits [BLK_W-1:0] plus one. The engine stays busy until `eng_done`.
- R6: Opcode 0x11 (DMA complete) emits one `dfin_pulse` and leaves the engine idle.
- R7: Opcode 0x22 (memory move) takes its direction from bit 25 (1 means internal RAM to external memory) and its word count from bits [24:12]. It takes the address from the next queue word. `stat_dma_busy` stays high from acceptance until `mdma_done`.
- R8: Opcode 0x15 (table load) with table select bits [25:24] equal to 3, RAM select bit 23 set and bit 20 set produces KT_WORDS consecutive `kt_xfer` cycles. These cycles carry word indices 0 upward, with `kt_slot` taken from bits [19:17].
- R9: A table load with a wrong table select, a clear RAM select or bit 20 clear is dropped and sets `stat_bad_op`.
- R10: Any other opcode is dropped with no action and sets the sticky `stat_bad_op`, which writing 1 to clear bit 0 resets.
- R11: When the engine leaves busy while `irq_en` is high, `irq` rises and holds until clear bit 2 is written. With `irq_en` low, it stays low.
- R12: A two-word command whose address word has not yet arrived keeps the engine busy and emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Push `cmd_data` into the queue |
| cmd_data | input | 32 | Command or address word |
| irq_en | input | 1 | Completion interrupt enable |
| clr_valid | input | 1 | Write-1-to-clear strobe |
| clr_bits | input | 3 | Clear mask: bit0 bad op, bit1 overflow, bit2 done |
| eng_done | input | 1 | Block engine finished |
| mdma_done | input | 1 | Memory move finished |
| dset_valid | output | 1 | DMA address program pulse |
| dset_addr | output | 32 | DMA address |
| eng_start | output | 1 | Block engine start pulse |
| eng_blocks | output | BLK_W+1 | Number of 16-byte blocks |
| dfin_pulse | output | 1 | DMA complete pulse |
| mdma_start | output | 1 | Memory move start pulse |
| mdma_to_ext | output | 1 | Move direction, 1 means internal RAM to external memory |
| mdma_words | output | MW_W | Move length in 32-bit words |
| mdma_addr | output | 32 | External memory address |
| kt_xfer | output | 1 | Key-table word transfer strobe |
| kt_word | output | $clog2(KT_WORDS) | Key-table word index |
| kt_slot | output | 3 | Destination key slot |
| stat_eng_busy | output | 1 | Engine busy status |
| stat_q_empty | output | 1 | Queue empty status |
| stat_dma_busy | output | 1 | DMA busy status |
| stat_bad_op | output | 1 | Sticky bad-command flag |
| stat_ovf | output | 1 | Sticky queue-overflow flag |
| irq | output | 1 | Level-high completion interrupt |

## Verification
The bench builds the block with its defaults: QDEPTH=5, BLK_W=16, MW_W=13 and KT_WORDS=16. With these values the queue can be filled exactly to its limit behind a stalled block start, so the sixth write lands on a full queue. They also make a block-count field of all ones carry into the extra result bit, and they let a whole 16-word key-table burst be watched index by index.

// File: rtl/crypto_cmdq_pkg.sv
package crypto_cmdq_pkg;

    localparam int OP_LSB      = 26;
    localparam int MDIR_BIT    = 25;
    localparam int MWORDS_LSB  = 12;
    localparam int TSEL_LSB    = 24;
    localparam int TRAM_BIT    = 23;
    localparam int TID_LSB     = 17;
    localparam int SLOT_W      = 3;

    localparam logic [5:0] OP_BLK  = 6'h0E;
    localparam logic [5:0] OP_DSET = 6'h10;
    localparam logic [5:0] OP_DFIN = 6'h11;
    localparam logic [5:0] OP_TBL  = 6'h15;
    localparam logic [5:0] OP_MDMA = 6'h22;

    localparam logic [1:0] TSEL_CRYPTO = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DADDR,
        ST_MADDR,
        ST_MDMA,
        ST_CRYPT,
        ST_TBL
    } seq_state_e;

endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full,
    output logic         ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             push, pull;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign push    = wr_en && !full;
    assign pull    = rd_en && !empty;
    assign ovf     = wr_en && full;
    assign rd_data = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == LAST) ? '0 : wp + PTR_W'(1);
            if (pull) rp <= (rp == LAST) ? '0 : rp + PTR_W'(1);
            if (push && !pull)      cnt <= cnt + CNT_W'(1);
            else if (pull && !push) cnt <= cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wr_data;
    end

    p_full_write_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> (cnt == $past(cnt)))
        else $error("write to full queue changed occupancy");

    p_pop_needs_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty)
        else $error("pop from empty queue");

endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
    import crypto_cmdq_pkg::*;
#(
    parameter int BLK_W    = 16,
    parameter int MW_W     = 13,
    parameter int KT_WORDS = 16,
    localparam int KW_W    = $clog2(KT_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       head,
    input  logic              empty,
    input  logic              eng_done,
    input  logic              mdma_done,
    output logic              pop,
    output logic              bad_op,
    output logic              dset_valid,
    output logic [31:0]       dset_addr,
    output logic              eng_start,
    output logic [BLK_W:0]    eng_blocks,
    output logic              dfin_pulse,
    output logic              mdma_start,
    output logic              mdma_to_ext,
    output logic [MW_W-1:0]   mdma_words,
    output logic [31:0]       mdma_addr,
    output logic              kt_xfer,
    output logic [KW_W-1:0]   kt_word,
    output logic [SLOT_W-1:0] kt_slot,
    output logic              eng_busy,
    output logic              dma_busy
);
    localparam logic [KW_W-1:0] KW_LAST = KW_W'(KT_WORDS - 1);

    seq_state_e        state, nxt;
    logic              mdir_q;
    logic [MW_W-1:0]   mwords_q;
    logic [SLOT_W-1:0] slot_q;
    logic [KW_W-1:0]   kw_q;
    logic [5:0]        op;
    logic              tbl_ok;

    assign op     = head[OP_LSB +: 6];
    assign tbl_ok = (head[TSEL_LSB +: 2] == TSEL_CRYPTO) && head[TRAM_BIT]
                    && head[TID_LSB + SLOT_W];

    // state register and operand latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mdir_q   <= 1'b0;
            mwords_q <= '0;
            slot_q   <= '0;
            kw_q     <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && pop && op == OP_MDMA) begin
                mdir_q   <= head[MDIR_BIT];
                mwords_q <= head[MWORDS_LSB +: MW_W];
            end
            if (state == ST_IDLE && pop && op == OP_TBL) begin
                slot_q <= head[TID_LSB +: SLOT_W];
                kw_q   <= '0;
            end else if (state == ST_TBL) begin
                kw_q <= kw_q + KW_W'(1);
            end
        end
    end

    // next state and outputs
    always_comb begin
        nxt        = state;
        pop        = 1'b0;
        bad_op     = 1'b0;
        dset_valid = 1'b0;
        eng_start  = 1'b0;
        dfin_pulse = 1'b0;
        mdma_start = 1'b0;
        kt_xfer    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!empty) begin
                    pop = 1'b1;
                    case (op)
                        OP_BLK: begin
                            eng_start = 1'b1;
                            nxt       = ST_CRYPT;
                        end
                        OP_DSET: nxt = ST_DADDR;
                        OP_DFIN: dfin_pulse = 1'b1;
                        OP_MDMA: nxt = ST_MADDR;
                        OP_TBL: begin
                            if (tbl_ok) nxt = ST_TBL;
                            else        bad_op = 1'b1;
                        end
                        default: bad_op = 1'b1;
                    endcase
                end
            end
            ST_DADDR: begin
                if (!empty) begin
                    pop        = 1'b1;
                    dset_valid = 1'b1;
                    nxt        = ST_IDLE;
                end
            end
            ST_MADDR: begin
                if (!empty) begin
                    pop        = 1'b1;
                    mdma_start = 1'b1;
                    nxt        = ST_MDMA;
                end
            end
            ST_MDMA:  if (mdma_done) nxt = ST_IDLE;
            ST_CRYPT: if (eng_done)  nxt = ST_IDLE;
            ST_TBL: begin
                kt_xfer = 1'b1;
                if (kw_q == KW_LAST) nxt = ST_IDLE;
            end
        endcase
    end

    assign dset_addr   = head;
    assign mdma_addr   = head;
    assign eng_blocks  = {1'b0, head[BLK_W-1:0]} + (BLK_W+1)'(1);
    assign mdma_to_ext = mdir_q;
    assign mdma_words  = mwords_q;
    assign kt_word     = kw_q;
    assign kt_slot     = slot_q;
    assign eng_busy    = (state != ST_IDLE);
    assign dma_busy    = (state == ST_MADDR) || (state == ST_MDMA);

    p_single_action_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dset_valid, eng_start, dfin_pulse, mdma_start, kt_xfer, bad_op}))
        else $error("more than one action in a cycle");

    p_mdma_keeps_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mdma_start |=> dma_busy)
        else $error("DMA busy dropped after move start");

    p_kt_index_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kt_xfer && $past(kt_xfer)) |-> (kt_word == $past(kt_word) + KW_W'(1)))
        else $error("key-table index skipped");

    p_addr_wait_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DADDR && empty) |=> !$past(dset_valid) && eng_busy)
        else $error("action without its address word");

endmodule

// File: rtl/cmdq_status.sv
module cmdq_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bad_set,
    input  logic       ovf_set,
    input  logic       eng_busy,
    input  logic       irq_en,
    input  logic       clr_valid,
    input  logic [2:0] clr_bits,
    output logic       stat_bad_op,
    output logic       stat_ovf,
    output logic       irq
);
    logic busy_q;
    logic done_set;
    logic [2:0] clr;

    assign clr      = clr_valid ? clr_bits : 3'b000;
    assign done_set = busy_q && !eng_busy && irq_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            stat_bad_op <= 1'b0;
            stat_ovf    <= 1'b0;
            irq         <= 1'b0;
        end else begin
            busy_q      <= eng_busy;
            stat_bad_op <= bad_set  || (stat_bad_op && !clr[0]);
            stat_ovf    <= ovf_set  || (stat_ovf    && !clr[1]);
            irq         <= done_set || (irq         && !clr[2]);
        end
    end

    p_irq_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr[2]) |=> irq)
        else $error("interrupt dropped without clear");

    p_bad_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_bad_op && !clr[0]) |=> stat_bad_op)
        else $error("bad-op flag dropped without clear");

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ovf && !clr[1]) |=> stat_ovf)
        else $error("overflow flag dropped without clear");

endmodule

// File: rtl/crypto_cmdq.sv
module crypto_cmdq
    import crypto_cmdq_pkg::*;
#(
    parameter int QDEPTH   = 5,
    parameter int BLK_W    = 16,
    parameter int MW_W     = 13,
    parameter int KT_WORDS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_wr,
    input  logic [31:0]                 cmd_data,
    input  logic                        irq_en,
    input  logic                        clr_valid,
    input  logic [2:0]                  clr_bits,
    input  logic                        eng_done,
    input  logic                        mdma_done,
    output logic                        dset_valid,
    output logic [31:0]                 dset_addr,
    output logic                        eng_start,
    output logic [BLK_W:0]              eng_blocks,
    output logic                        dfin_pulse,
    output logic                        mdma_start,
    output logic                        mdma_to_ext,
    output logic [MW_W-1:0]             mdma_words,
    output logic [31:0]                 mdma_addr,
    output logic                        kt_xfer,
    output logic [$clog2(KT_WORDS)-1:0] kt_word,
    output logic [SLOT_W-1:0]           kt_slot,
    output logic                        stat_eng_busy,
    output logic                        stat_q_empty,
    output logic                        stat_dma_busy,
    output logic                        stat_bad_op,
    output logic                        stat_ovf,
    output logic                        irq
);
    logic [31:0] head;
    logic        empty, full, ovf, pop, bad_op;

    cmdq_fifo #(.W(32), .DEPTH(QDEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmd_wr),
        .wr_data (cmd_data),
        .rd_en   (pop),
        .rd_data (head),
        .empty   (empty),
        .full    (full),
        .ovf     (ovf)
    );

    cmdq_seq #(.BLK_W(BLK_W), .MW_W(MW_W), .KT_WORDS(KT_WORDS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .head        (head),
        .empty       (empty),
        .eng_done    (eng_done),
        .mdma_done   (mdma_done),
        .pop         (pop),
        .bad_op      (bad_op),
        .dset_valid  (dset_valid),
        .dset_addr   (dset_addr),
        .eng_start   (eng_start),
        .eng_blocks  (eng_blocks),
        .dfin_pulse  (dfin_pulse),
        .mdma_start  (mdma_start),
        .mdma_to_ext (mdma_to_ext),
        .mdma_words  (mdma_words),
        .mdma_addr   (mdma_addr),
        .kt_xfer     (kt_xfer),
        .kt_word     (kt_word),
        .kt_slot     (kt_slot),
        .eng_busy    (stat_eng_busy),
        .dma_busy    (stat_dma_busy)
    );

    cmdq_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .bad_set     (bad_op),
        .ovf_set     (ovf),
        .eng_busy    (stat_eng_busy),
        .irq_en      (irq_en),
        .clr_valid   (clr_valid),
        .clr_bits    (clr_bits),
        .stat_bad_op (stat_bad_op),
        .stat_ovf    (stat_ovf),
        .irq         (irq)
    );

    assign stat_q_empty = empty;

    p_full_not_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !stat_q_empty)
        else $error("full queue reported empty");

endmodule

// File: tb/test_crypto_cmdq.sv
module test_crypto_cmdq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_data = '0;
    logic        irq_en = 1'b0;
    logic        clr_valid = 1'b0;
    logic [2:0]  clr_bits = '0;
    logic        eng_done = 1'b0;
    logic        mdma_done = 1'b0;

    logic        dset_valid, eng_start, dfin_pulse, mdma_start, mdma_to_ext, kt_xfer;
    logic [31:0] dset_addr, mdma_addr;
    logic [16:0] eng_blocks;
    logic [12:0] mdma_words;
    logic [3:0]  kt_word;
    logic [2:0]  kt_slot;
    logic        stat_eng_busy, stat_q_empty, stat_dma_busy, stat_bad_op, stat_ovf, irq;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    crypto_cmdq i_crypto_cmdq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .irq_en(irq_en), .clr_valid(clr_valid), .clr_bits(clr_bits),
        .eng_done(eng_done), .mdma_done(mdma_done),
        .dset_valid(dset_valid), .dset_addr(dset_addr),
        .eng_start(eng_start), .eng_blocks(eng_blocks), .dfin_pulse(dfin_pulse),
        .mdma_start(mdma_start), .mdma_to_ext(mdma_to_ext), .mdma_words(mdma_words),
        .mdma_addr(mdma_addr), .kt_xfer(kt_xfer), .kt_word(kt_word), .kt_slot(kt_slot),
        .stat_eng_busy(stat_eng_busy), .stat_q_empty(stat_q_empty),
        .stat_dma_busy(stat_dma_busy), .stat_bad_op(stat_bad_op),
        .stat_ovf(stat_ovf), .irq(irq)
    );

    // action monitors, sampled away from the active edge
    int          n_dset = 0, n_est = 0, n_dfin = 0, n_mst = 0, n_kt = 0, n_ktbad = 0;
    logic [31:0] a_dset = '0, a_maddr = '0;
    logic [16:0] a_blk = '0;
    logic        a_mdir = 1'b0;
    logic [12:0] a_mw = '0;
    logic [2:0]  a_slot = '0;
    logic [3:0]  kt_next = '0;

    always @(negedge clk) begin
        if (dset_valid) begin n_dset++; a_dset = dset_addr; end
        if (eng_start)  begin n_est++;  a_blk  = eng_blocks; end
        if (dfin_pulse) n_dfin++;
        if (mdma_start) begin n_mst++; a_mdir = mdma_to_ext; a_mw = mdma_words; a_maddr = mdma_addr; end
        if (kt_xfer) begin
            if (kt_word != kt_next) n_ktbad++;
            kt_next = kt_word + 4'd1;
            n_kt++;
            a_slot = kt_slot;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired act=timeout exp=finish");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [25:0] rest);
        return {op, rest};
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk); cmd_wr = 1'b1; cmd_data = w;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic clear(input logic [2:0] bits);
        @(negedge clk); clr_valid = 1'b1; clr_bits = bits;
        @(negedge clk); clr_valid = 1'b0; clr_bits = '0;
        #1;
    endtask

    task automatic pulse_eng_done();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic pulse_mdma_done();
        @(negedge clk); mdma_done = 1'b1;
        @(negedge clk); mdma_done = 1'b0;
    endtask

    task automatic t_reset();
        chk(stat_q_empty == 1'b1, "R1 queue empty", stat_q_empty, 1);
        chk({stat_eng_busy, stat_dma_busy} == 2'b00, "R1 busy low", {stat_eng_busy, stat_dma_busy}, 0);
        chk({stat_bad_op, stat_ovf, irq} == 3'b000, "R1 flags low", {stat_bad_op, stat_ovf, irq}, 0);
    endtask

    task automatic t_dma_setup();
        int d0 = n_dset;
        push(mk(6'h10, 26'h0));
        idle(4);
        chk(n_dset == d0, "R12 no action before address", n_dset - d0, 0);
        chk(stat_eng_busy == 1'b1, "R12 busy waiting for address", stat_eng_busy, 1);
        push(32'hCAFE_0010);
        idle(3);
        chk(n_dset == d0 + 1, "R4 one setup pulse", n_dset - d0, 1);
        chk(a_dset == 32'hCAFE_0010, "R4 setup address", a_dset, 32'hCAFE_0010);
        chk(stat_eng_busy == 1'b0, "R4 idle after setup", stat_eng_busy, 0);
    endtask

    task automatic t_block(input logic [15:0] field, input logic [16:0] exp_blk);
        int e0 = n_est;
        push(mk(6'h0E, {10'h0, field}));
        idle(2);
        chk(n_est == e0 + 1, "R5 one start pulse", n_est - e0, 1);
        chk(a_blk == exp_blk, "R5 block count", a_blk, exp_blk);
        idle(5);
        chk(stat_eng_busy == 1'b1, "R5 busy until done", stat_eng_busy, 1);
        pulse_eng_done();
        idle(2);
        chk(stat_eng_busy == 1'b0, "R5 idle after done", stat_eng_busy, 0);
    endtask

    task automatic t_dfin();
        int f0 = n_dfin;
        push(mk(6'h11, 26'h0));
        idle(3);
        chk(n_dfin == f0 + 1, "R6 complete pulse", n_dfin - f0, 1);
        chk(stat_eng_busy == 1'b0, "R6 engine idle", stat_eng_busy, 0);
        chk(irq == 1'b0, "R11 no irq while disabled", irq, 0);
    endtask

    task automatic t_mdma(input logic dir, input logic [12:0] words, input logic [31:0] addr);
        int m0 = n_mst;
        push(mk(6'h22, {dir, words, 12'h0}));
        idle(1);
        chk(stat_dma_busy == 1'b1, "R7 dma busy before address", stat_dma_busy, 1);
        push(addr);
        idle(2);
        chk(n_mst == m0 + 1, "R7 one move start", n_mst - m0, 1);
        chk({a_mdir, a_mw} == {dir, words}, "R7 direction and count", {a_mdir, a_mw}, {dir, words});
        chk(a_maddr == addr, "R7 move address", a_maddr, addr);
        idle(4);
        chk(stat_dma_busy == 1'b1, "R7 busy until done", stat_dma_busy, 1);
        pulse_mdma_done();
        idle(2);
        chk(stat_dma_busy == 1'b0, "R7 dma idle after done", stat_dma_busy, 0);
    endtask

    task automatic t_table(input logic [2:0] slot);
        int k0 = n_kt, kb = n_ktbad;
        push(mk(6'h15, {2'd3, 1'b1, 2'b00, 1'b1, slot, 17'h0}));
        idle(24);
        chk(n_kt == k0 + 16, "R8 sixteen words", n_kt - k0, 16);
        chk(n_ktbad == kb, "R8 index order", n_ktbad - kb, 0);
        chk(a_slot == slot, "R8 slot", a_slot, slot);
        chk(stat_bad_op == 1'b0, "R8 no error", stat_bad_op, 0);
    endtask

    task automatic t_bad_table(input logic [25:0] rest, input string tag);
        int k0 = n_kt;
        push(mk(6'h15, rest));
        idle(20);
        chk(n_kt == k0, {"R9 no transfer ", tag}, n_kt - k0, 0);
        chk(stat_bad_op == 1'b1, {"R9 error set ", tag}, stat_bad_op, 1);
        clear(3'b001);
    endtask

    task automatic t_unknown();
        int e0 = n_est, f0 = n_dfin, d0 = n_dset, m0 = n_mst;
        push(mk(6'h3F, 26'h3FF_FFFF));
        idle(3);
        chk(stat_bad_op == 1'b1, "R10 error set", stat_bad_op, 1);
        chk((n_est + n_dfin + n_dset + n_mst) == (e0 + f0 + d0 + m0), "R10 no action",
            n_est + n_dfin + n_dset + n_mst - e0 - f0 - d0 - m0, 0);
        chk(stat_eng_busy == 1'b0, "R10 engine idle", stat_eng_busy, 0);
        idle(4);
        chk(stat_bad_op == 1'b1, "R10 error sticky", stat_bad_op, 1);
        clear(3'b001);
        chk(stat_bad_op == 1'b0, "R10 error cleared", stat_bad_op, 0);
    endtask

    task automatic t_overflow();
        int f0 = n_dfin;
        push(mk(6'h0E, 26'h0));
        idle(3);
        for (int i = 0; i < 5; i++) push(mk(6'h11, 26'h0));
        idle(1);
        chk(stat_q_empty == 1'b0, "R2 queue holds words", stat_q_empty, 0);
        chk(stat_ovf == 1'b0, "R2 five words fit", stat_ovf, 0);
        push(mk(6'h3F, 26'h0));
        idle(1);
        chk(stat_ovf == 1'b1, "R3 overflow flag", stat_ovf, 1);
        pulse_eng_done();
        idle(10);
        chk(n_dfin == f0 + 5, "R2 five commands run", n_dfin - f0, 5);
        chk(stat_bad_op == 1'b0, "R3 dropped word not run", stat_bad_op, 0);
        chk(stat_q_empty == 1'b1, "R2 queue drained", stat_q_empty, 1);
        clear(3'b010);
        chk(stat_ovf == 1'b0, "R3 overflow cleared", stat_ovf, 0);
    endtask

    task automatic t_irq();
        irq_en = 1'b1;
        push(mk(6'h0E, 26'h3));
        idle(3);
        chk(irq == 1'b0, "R11 no irq while busy", irq, 0);
        pulse_eng_done();
        idle(3);
        chk(irq == 1'b1, "R11 irq on idle", irq, 1);
        idle(6);
        chk(irq == 1'b1, "R11 irq held", irq, 1);
        clear(3'b100);
        chk(irq == 1'b0, "R11 irq cleared", irq, 0);
        irq_en = 1'b0;
        push(mk(6'h0E, 26'h0));
        idle(3);
        pulse_eng_done();
        idle(4);
        chk(irq == 1'b0, "R11 irq masked", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_dma_setup();
        t_block(16'd5, 17'd6);
        t_block(16'hFFFF, 17'h10000);
        t_dfin();
        t_mdma(1'b1, 13'd16, 32'h8000_0400);
        t_mdma(1'b0, 13'h1FFF, 32'h0000_1000);
        t_table(3'd5);
        t_table(3'd0);
        t_bad_table({2'd2, 1'b1, 2'b00, 1'b1, 3'd5, 17'h0}, "table select");
        t_bad_table({2'd3, 1'b0, 2'b00, 1'b1, 3'd5, 17'h0}, "ram select");
        t_bad_table({2'd3, 1'b1, 2'b00, 1'b0, 3'd5, 17'h0}, "id flag");
        t_unknown();
        t_overflow();
        t_irq();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule